// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block runs the hardware side of a receive descriptor ring in memory. Software writes three values through a small register port: the byte address of the ring, the number of slots, and a head index that hands slots to the hardware. The hardware keeps a tail index. Slots from tail up to, but not including, head belong to the hardware. When head equals tail, the hardware owns no slot.

When a packet is offered, the engine first compares head with tail. If the ring is full, it takes the packet off the handshake, drops it and counts the drop. Otherwise it reads the slot's first 64-bit word, which is the packet-buffer address placed there by the driver. It then asks a data mover to store the packet at that address. When the mover acknowledges, the engine overwrites the slot with a writeback record in two words. The second word carries the done flag. The engine then advances the tail, wrapping at the ring length.

The state machine has the states ST_IDLE, ST_FETCH, ST_FETCH_WAIT, ST_BUF, ST_WB_LO and ST_WB_HI, with these transitions:
- accept: ST_IDLE to ST_FETCH, on an offered packet when the ring is not full.
- drop: ST_IDLE stays in ST_IDLE, on an offered packet when the ring is full.
- read-granted: ST_FETCH to ST_FETCH_WAIT.
- read-returned: ST_FETCH_WAIT to ST_BUF.
- buffer-acked: ST_BUF to ST_WB_LO.
- low-written: ST_WB_LO to ST_WB_HI.
- high-written: ST_WB_HI to ST_IDLE, which also advances the tail.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset, tail_idx, drop_count and head_err are all 0, and pkt_ready is 1. The ring base, ring length and head are also 0, so every packet is dropped until software programs the ring.
- R2: A register write with reg_we high uses reg_addr to select the target: 0 writes the ring base byte address, 1 writes the ring length in slots, and 2 writes the head index. A write to reg_addr 3 has no effect.
- R3: A head write whose value is at least the ring length, or at least MAX_RING, leaves head unchanged and sets head_err. head_err stays 1 until reset.
- R4: A packet offered while head equals tail is taken (pkt_ready high) and dropped. drop_count increments by 1, and the drop causes no memory access, no buffer request and no tail change.
- R5: An accepted packet causes one 64-bit read at base + 16*tail. The returned word appears on buf_addr, and the packet length appears on buf_len. buf_req stays high, with buf_addr stable, until buf_ack.
- R6: After buf_ack, the engine writes a first writeback word to base + 16*tail with this layout: bits 15:0 zero, bits 31:16 the VLAN tag, bits 63:32 the hash.
- R7: The engine then writes a second writeback word to base + 16*tail + 8 with this layout: bit 0 the done flag (1), bit 19 a bad-checksum flag (1 when pkt_csum_ok is 0), bits 51:38 the 14-bit length, and all other bits 0.
- R8: The buffer acknowledge comes before any descriptor write for a packet, and the first writeback word is written before the second.
- R9: The tail advances by one after the second word is accepted, and it becomes 0 instead of reaching the ring length.
- R10: pkt_ready is high only in the idle state. The engine handles one packet at a time, from acceptance until the tail advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Packet taken when both are high |
| pkt_len | input | 14 | Packet length in bytes |
| pkt_csum_ok | input | 1 | Checksum result, 1 when good |
| pkt_vlan | input | 16 | VLAN tag |
| pkt_hash | input | 32 | Flow hash |
| buf_req | output | 1 | Request to store the packet |
| buf_addr | output | 64 | Packet-buffer address from the descriptor |
| buf_len | output | 14 | Length to store |
| buf_ack | input | 1 | Store complete |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| tail_idx | output | 10 | Hardware tail index |
| drop_count | output | 16 | Packets dropped on a full ring |
| head_err | output | 1 | Sticky flag for an out-of-range head write |

## Verification
The bench starts by offering a packet to the unprogrammed ring. A design that treats head equal to tail as empty would fetch a descriptor there instead of dropping the packet.

It then fills the ring until tail meets head and offers one more packet. A wrong fullness test would overwrite a slot still owned by software.

It writes an out-of-range head and then a legal one. A design that accepts the bad head would pass packets it should refuse, and a design whose flag is not sticky would clear head_err.

It checks every bit of both writeback words, including a maximum-length packet with a bad checksum, so a misplaced field or missing done flag is caught. It also checks the order of the buffer acknowledge and the two word writes, and the tail wrap from the last slot to slot 0.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;

    localparam int WORD_W      = 64;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int SLOT_BYTES  = 2 * WORD_BYTES;
    localparam int SLOT_SHIFT  = $clog2(SLOT_BYTES);

    localparam int PLEN_W      = 14;
    localparam int VLAN_W      = 16;
    localparam int HASH_W      = 32;
    localparam int CTX_W       = 16;

    // first writeback word
    localparam int CTX_LSB     = 0;
    localparam int VLAN_LSB    = CTX_LSB + CTX_W;
    localparam int HASH_LSB    = VLAN_LSB + VLAN_W;

    // second writeback word
    localparam int DONE_BIT    = 0;
    localparam int BADCSUM_BIT = 19;
    localparam int PLEN_LSB    = 38;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_FETCH      = 3'd1,
        ST_FETCH_WAIT = 3'd2,
        ST_BUF        = 3'd3,
        ST_WB_LO      = 3'd4,
        ST_WB_HI      = 3'd5
    } ring_state_t;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_HEAD = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    typedef struct packed {
        logic [PLEN_W-1:0] len;
        logic              csum_ok;
        logic [VLAN_W-1:0] vlan;
        logic [HASH_W-1:0] hash;
    } pkt_info_t;

endpackage

// File: rtl/rxr_regs.sv
`timescale 1ns/1ps
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int MAX_RING = 1024,
    parameter int DROP_W   = 16,
    parameter int IDX_W    = 10,
    parameter int LEN_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              drop_i,
    output logic [REG_W-1:0]  base_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [IDX_W-1:0]  head_o,
    output logic              head_err_o,
    output logic [DROP_W-1:0] drop_cnt_o
);

    logic     head_ok;
    reg_sel_t sel;

    assign sel     = reg_sel_t'(addr);
    assign head_ok = (wdata < REG_W'(len_o)) && (wdata < REG_W'(MAX_RING));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o     <= '0;
            len_o      <= '0;
            head_o     <= '0;
            head_err_o <= 1'b0;
        end else if (we) begin
            unique case (sel)
                SEL_BASE: base_o <= wdata;
                SEL_LEN:  len_o  <= wdata[LEN_W-1:0];
                SEL_HEAD: begin
                    if (head_ok) head_o     <= wdata[IDX_W-1:0];
                    else         head_err_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      drop_cnt_o <= '0;
        else if (drop_i) drop_cnt_o <= drop_cnt_o + 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(head_err_o) |-> head_err_o) else $error("head_err cleared"); // R3

    AST_HEAD_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (head_o != $past(head_o)) |-> $past(we && (addr == 2'd2) && head_ok))
        else $error("head changed without a legal write"); // R3

endmodule

// File: rtl/rxr_wb_pack.sv
`timescale 1ns/1ps
module rxr_wb_pack
    import rxr_pkg::*;
(
    input  pkt_info_t         info_i,
    output logic [WORD_W-1:0] wb_lo_o,
    output logic [WORD_W-1:0] wb_hi_o
);

    always_comb begin
        wb_lo_o = '0;
        wb_lo_o[CTX_LSB  +: CTX_W]  = '0;
        wb_lo_o[VLAN_LSB +: VLAN_W] = info_i.vlan;
        wb_lo_o[HASH_LSB +: HASH_W] = info_i.hash;
    end

    always_comb begin
        wb_hi_o = '0;
        wb_hi_o[DONE_BIT]             = 1'b1;
        wb_hi_o[BADCSUM_BIT]          = ~info_i.csum_ok;
        wb_hi_o[PLEN_LSB +: PLEN_W]   = info_i.len;
    end

endmodule

// File: rtl/rxr_fsm.sv
`timescale 1ns/1ps
module rxr_fsm
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [IDX_W-1:0]  head_i,
    input  logic              pkt_valid_i,
    output logic              pkt_ready_o,
    input  pkt_info_t         pkt_i,
    output pkt_info_t         held_o,
    output logic              drop_o,
    output logic              buf_req_o,
    output logic [WORD_W-1:0] buf_addr_o,
    input  logic              buf_ack_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic [WORD_W-1:0] wb_lo_i,
    input  logic [WORD_W-1:0] wb_hi_i,
    output logic [IDX_W-1:0]  tail_o
);

    ring_state_t       state_q, state_d;
    logic [IDX_W-1:0]  tail_q, tail_inc;
    logic              ring_full, tail_wrap, accept;
    logic [ADDR_W-1:0] slot_addr;

    assign ring_full = (head_i == tail_q);
    assign accept    = (state_q == ST_IDLE) && pkt_valid_i && !ring_full;
    assign tail_wrap = (LEN_W'(tail_q) + LEN_W'(1)) >= len_i;
    assign tail_inc  = tail_wrap ? '0 : tail_q + 1'b1;
    assign slot_addr = base_i + (ADDR_W'(tail_q) << SLOT_SHIFT);
    assign tail_o    = tail_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (accept)       state_d = ST_FETCH;
            ST_FETCH:      if (mem_gnt_i)    state_d = ST_FETCH_WAIT;
            ST_FETCH_WAIT: if (mem_rvalid_i) state_d = ST_BUF;
            ST_BUF:        if (buf_ack_i)    state_d = ST_WB_LO;
            ST_WB_LO:      if (mem_gnt_i)    state_d = ST_WB_HI;
            ST_WB_HI:      if (mem_gnt_i)    state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pkt_ready_o = 1'b0;
        drop_o      = 1'b0;
        buf_req_o   = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = slot_addr;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                pkt_ready_o = 1'b1;
                drop_o      = pkt_valid_i && ring_full;
            end
            ST_FETCH: mem_req_o = 1'b1;
            ST_FETCH_WAIT: ;
            ST_BUF:   buf_req_o = 1'b1;
            ST_WB_LO: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = wb_lo_i;
            end
            ST_WB_HI: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = slot_addr + ADDR_W'(WORD_BYTES);
                mem_wdata_o = wb_hi_i;
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q     <= '0;
            held_o     <= '0;
            buf_addr_o <= '0;
        end else begin
            if (accept) held_o <= pkt_i;
            if ((state_q == ST_FETCH_WAIT) && mem_rvalid_i) buf_addr_o <= mem_rdata_i;
            if ((state_q == ST_WB_HI) && mem_gnt_i) tail_q <= tail_inc;
        end
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_req_o && !buf_ack_i) |=> (buf_req_o && $stable(buf_addr_o)))
        else $error("buffer request dropped early"); // R5

    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q != $past(tail_q)) |-> ((tail_q == $past(tail_q) + 1'b1) || (tail_q == '0)))
        else $error("tail jumped"); // R9

    AST_DONE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_gnt_i && mem_wdata_o[DONE_BIT] && (len_i > LEN_W'(1)))
        |=> (tail_q != $past(tail_q))) else $error("done written without tail advance"); // R9

    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid_i && pkt_ready_o && !ring_full) |=> !pkt_ready_o)
        else $error("ready while busy"); // R10

    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> !mem_req_o) else $error("memory access after drop"); // R4

endmodule

// File: rtl/rx_desc_ring.sv
`timescale 1ns/1ps
module rx_desc_ring
    import rxr_pkg::*;
#(
    parameter  int REG_W    = 32,
    parameter  int MAX_RING = 1024,
    parameter  int DROP_W   = 16,
    localparam int IDX_W    = $clog2(MAX_RING),
    localparam int LEN_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [13:0]       pkt_len,
    input  logic              pkt_csum_ok,
    input  logic [15:0]       pkt_vlan,
    input  logic [31:0]       pkt_hash,
    output logic              buf_req,
    output logic [63:0]       buf_addr,
    output logic [13:0]       buf_len,
    input  logic              buf_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [REG_W-1:0]  mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic [IDX_W-1:0]  tail_idx,
    output logic [DROP_W-1:0] drop_count,
    output logic              head_err
);

    logic [REG_W-1:0]  ring_base;
    logic [LEN_W-1:0]  ring_len;
    logic [IDX_W-1:0]  head_idx;
    logic              drop_pulse;
    pkt_info_t         pkt_in, pkt_held;
    logic [WORD_W-1:0] wb_lo, wb_hi;

    assign pkt_in  = '{len: pkt_len, csum_ok: pkt_csum_ok, vlan: pkt_vlan, hash: pkt_hash};
    assign buf_len = pkt_held.len;

    rxr_regs #(
        .REG_W(REG_W), .MAX_RING(MAX_RING), .DROP_W(DROP_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .drop_i(drop_pulse), .base_o(ring_base), .len_o(ring_len), .head_o(head_idx),
        .head_err_o(head_err), .drop_cnt_o(drop_count)
    );

    rxr_wb_pack u_pack (
        .info_i(pkt_held), .wb_lo_o(wb_lo), .wb_hi_o(wb_hi)
    );

    rxr_fsm #(
        .ADDR_W(REG_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .base_i(ring_base), .len_i(ring_len), .head_i(head_idx),
        .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready), .pkt_i(pkt_in), .held_o(pkt_held),
        .drop_o(drop_pulse), .buf_req_o(buf_req), .buf_addr_o(buf_addr), .buf_ack_i(buf_ack),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .wb_lo_i(wb_lo), .wb_hi_i(wb_hi), .tail_o(tail_idx)
    );

    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> $past(head_idx == tail_idx))
        else $error("drop counted with free slots"); // R4

endmodule

// File: tb/rx_desc_ring_tb.sv
`timescale 1ns/1ps
module rx_desc_ring_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        pkt_valid = 1'b0;
    logic        pkt_ready;
    logic [13:0] pkt_len = '0;
    logic        pkt_csum_ok = 1'b1;
    logic [15:0] pkt_vlan = '0;
    logic [31:0] pkt_hash = '0;
    logic        buf_req;
    logic [63:0] buf_addr;
    logic [13:0] buf_len;
    logic        buf_ack = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_gnt;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [9:0]  tail_idx;
    logic [15:0] drop_count;
    logic        head_err;

    int n_checks = 0, n_bad = 0;
    int seq = 0, lo_seq = 0, hi_seq = 0, buf_seq = 0;
    int mem_acc = 0, buf_cycles = 0;
    logic [31:0] last_rd_addr = '0;
    logic [63:0] mem [0:127];

    assign mem_gnt = 1'b1;

    always #2.5 clk = ~clk;

    rx_desc_ring u_dut (.*);

    // descriptor memory model: one-cycle read latency, always grants
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (buf_req) buf_cycles++;
        if (mem_req) begin
            mem_acc++;
            if (mem_we) begin
                mem[mem_addr[9:3]] = mem_wdata;
                seq++;
                if (mem_addr[3]) hi_seq = seq; else lo_seq = seq;
            end else begin
                last_rd_addr = mem_addr;
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[9:3]];
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic offer(input logic [13:0] len, input logic ok, input logic [15:0] vlan,
                         input logic [31:0] hash);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_len = len; pkt_csum_ok = ok; pkt_vlan = vlan; pkt_hash = hash;
        while (!pkt_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic expect_drop(input string tag, input logic [15:0] exp_drop);
        int acc0, buf0;
        logic [9:0] t0;
        acc0 = mem_acc; buf0 = buf_cycles; t0 = tail_idx;
        offer(14'd60, 1'b1, 16'h0, 32'h0);
        repeat (4) @(negedge clk);
        chk({tag, " R4 drop count"}, 64'(drop_count), 64'(exp_drop));
        chk({tag, " R4 no memory access"}, 64'(mem_acc), 64'(acc0));
        chk({tag, " R4 no buffer request"}, 64'(buf_cycles), 64'(buf0));
        chk({tag, " R4 tail unchanged"}, 64'(tail_idx), 64'(t0));
    endtask

    task automatic run_pkt(input int slot, input logic [13:0] len, input logic ok,
                           input logic [15:0] vlan, input logic [31:0] hash,
                           input logic [9:0] exp_tail);
        logic [63:0] exp_buf, exp_lo, exp_hi;
        int waited;
        exp_buf = mem[2*slot];
        exp_lo  = {hash, vlan, 16'h0000};
        exp_hi  = (64'(len) << 38) | (ok ? 64'd0 : (64'd1 << 19)) | 64'd1;
        offer(len, ok, vlan, hash);
        waited = 0;
        while (!buf_req && waited < 20) begin @(negedge clk); waited++; end
        chk("R5 buffer request seen", 64'(buf_req), 64'd1);
        chk("R2 R5 descriptor read address", 64'(last_rd_addr), 64'(32'h1000 + 16*slot));
        chk("R5 buffer address", buf_addr, exp_buf);
        chk("R5 buffer length", 64'(buf_len), 64'(len));
        chk("R10 not ready while busy", 64'(pkt_ready), 64'd0);
        repeat (2) @(negedge clk);
        chk("R5 request held until ack", 64'(buf_req), 64'd1);
        buf_ack = 1'b1;
        @(posedge clk);
        seq++; buf_seq = seq;
        @(negedge clk);
        buf_ack = 1'b0;
        waited = 0;
        while (tail_idx != exp_tail && waited < 20) begin @(negedge clk); waited++; end
        chk("R9 tail after writeback", 64'(tail_idx), 64'(exp_tail));
        chk("R6 first writeback word", mem[2*slot], exp_lo);
        chk("R7 second writeback word", mem[2*slot+1], exp_hi);
        chk("R8 ack before first word", 64'(buf_seq < lo_seq), 64'd1);
        chk("R8 first word before second", 64'(lo_seq < hi_seq), 64'd1);
        chk("R10 ready again", 64'(pkt_ready), 64'd1);
    endtask

    task automatic t_reset();
        chk("R1 tail", 64'(tail_idx), 64'd0);
        chk("R1 drops", 64'(drop_count), 64'd0);
        chk("R1 head_err", 64'(head_err), 64'd0);
        chk("R1 ready", 64'(pkt_ready), 64'd1);
        chk("R1 no requests", 64'({mem_req, buf_req}), 64'd0);
    endtask

    task automatic t_unprogrammed();
        expect_drop("unprogrammed R1", 16'd1);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 4; i++) begin
            mem[2*i]   = 64'hA500_0000_0000_0000 + 64'(i) * 64'h800;
            mem[2*i+1] = 64'hFFFF_FFFF_FFFF_FFFF;
        end
        wr_reg(2'd0, 32'h0000_1000);
        wr_reg(2'd1, 32'd4);
        wr_reg(2'd3, 32'd2);          // R2 unused select: no effect
        wr_reg(2'd2, 32'd3);
        chk("R2 head write legal", 64'(head_err), 64'd0);
        run_pkt(0, 14'd100, 1'b1, 16'h0123, 32'hDEAD_BEEF, 10'd1);
        run_pkt(1, 14'h3FFF, 1'b0, 16'hFFFF, 32'h0000_0001, 10'd2);
        run_pkt(2, 14'd64, 1'b1, 16'h0F00, 32'h1234_5678, 10'd3);
        expect_drop("ring full", 16'd2);
    endtask

    task automatic t_bad_head();
        wr_reg(2'd2, 32'd4);
        chk("R3 head_err set", 64'(head_err), 64'd1);
        expect_drop("R3 head kept", 16'd3);
        wr_reg(2'd2, 32'h0001_0001);
        expect_drop("R3 wide head kept", 16'd4);
    endtask

    task automatic t_wrap();
        mem[0] = 64'h5A5A_0000_0000_7000;
        wr_reg(2'd2, 32'd1);
        chk("R3 head_err sticky", 64'(head_err), 64'd1);
        run_pkt(3, 14'd1, 1'b1, 16'h0001, 32'hCAFE_0003, 10'd0);
        run_pkt(0, 14'd1514, 1'b0, 16'h00AB, 32'h0BAD_F00D, 10'd1);
        expect_drop("after wrap", 16'd5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unprogrammed();
        t_fill();
        t_bad_head();
        t_wrap();
        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule